// File: doc/BRIEF.md
# Registered ROM with initialize byte

This block is a read-only store of 8192 eight-bit words whose read port ends in an edge-triggered pipeline register. In normal operation, each rising clock edge captures the word selected by the 13-bit address, so the word shows on `dout` one edge after its address is presented. Two locations past the data array hold an initialize byte (location 8192) and a control byte (location 8193). All three come from parameters, and the data words come from a fixed formula over the address.

An active-low initialize input loads the initialize byte into the pipeline register the moment it falls, with no clock needed. For as long as it stays low, clock edges have no effect. The control byte selects how the output-enable flag `oe` follows the active-low enable input `en_n`: immediately, at the clock edge, or not at all (outputs always on). The flag stands in for tri-state drive, so the surrounding logic models the bus from `oe`.

Top module: `reg_init_rom`

## Requirements
- R1: With `mode_sel` low, `init_n` high and `rst` low, a rising `clk` edge loads the word at `addr` into the register. That word is `addr[7:0] XOR {addr[12:8],3'b000} XOR SEED` (SEED defaults to 8'hA5), and it appears on `dout` after that edge.
- R2: A rising edge with `rst` high (and `init_n` high) clears `dout` to 0 and turns off the synchronous enable state.
- R3: With `mode_sel` high, clock edges leave `dout` unchanged.
- R4: A falling edge on `init_n` puts the initialize byte (default 8'h3C, image location 8192) on `dout` before any clock edge.
- R5: While `init_n` is low, `dout` stays at the initialize byte whatever `addr` does across clock edges. After `init_n` returns high, the next edge loads the addressed word again.
- R6: Control byte 8'h00 (location 8193) gives asynchronous enable: `oe` equals NOT `en_n` at all times, with no clock needed.
- R7: Control byte 8'h01 gives synchronous enable: `oe` changes only at a rising `clk` edge, to NOT `en_n` as sampled at that edge.
- R8: Control byte 8'h02 gives initialize-only operation: `oe` is always 1, and `en_n` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Word address |
| mode_sel | input | 1 | High freezes the pipeline register |
| init_n | input | 1 | Active-low asynchronous initialize |
| en_n | input | 1 | Active-low output enable |
| dout | output | 8 | Pipeline register contents |
| oe | output | 1 | Outputs driven when 1 |

## Verification
The hardest case to reach is the initialize input falling between clock edges. The register must change at once, and then ignore edges that carry a fresh address. The stimulus drops `init_n` one nanosecond after a falling clock edge and samples `dout` before the next rising edge. It then holds `init_n` low across several edges with changing addresses, and raises it again just before an edge to show that loading resumes. Three instances, one for each control code, share the same inputs. This lets the bench compare the enable timings directly: a mid-cycle change of `en_n` must reach `oe` at once only in the asynchronous variant.

// File: rtl/rrom_pkg.sv
package rrom_pkg;

    localparam int unsigned ROM_ADDR_W = 13;
    localparam int unsigned ROM_DATA_W = 8;

    localparam logic [7:0] CODE_ASYNC_EN = 8'h00;
    localparam logic [7:0] CODE_SYNC_EN  = 8'h01;
    localparam logic [7:0] CODE_INIT_PIN = 8'h02;

    typedef enum logic [1:0] {
        OE_ASYNC    = 2'd0,
        OE_SYNC     = 2'd1,
        OE_FIXED_ON = 2'd2
    } oe_kind_e;

    typedef struct packed {
        logic clear;
        logic load;
    } load_ctrl_t;

    // Unknown codes fall back to the default asynchronous enable
    function automatic oe_kind_e decode_ctrl(input logic [7:0] code);
        case (code)
            CODE_SYNC_EN:  return OE_SYNC;
            CODE_INIT_PIN: return OE_FIXED_ON;
            default:       return OE_ASYNC;
        endcase
    endfunction

    // Data array contents: low byte of address mixed with the upper bits
    function automatic logic [31:0] array_word(input logic [31:0] a,
                                               input int unsigned dw,
                                               input logic [31:0] seed);
        logic [31:0] mask;
        logic [31:0] lo;
        logic [31:0] hi;
        mask = (32'd1 << dw) - 32'd1;
        lo   = a & mask;
        hi   = (a >> dw) << 3;
        return (lo ^ hi ^ seed) & mask;
    endfunction

    // Whole image: data array, then initialize byte, then control byte
    function automatic logic [31:0] image_word(input logic [31:0] a,
                                               input logic [31:0] depth,
                                               input int unsigned dw,
                                               input logic [31:0] seed,
                                               input logic [31:0] init_b,
                                               input logic [31:0] ctrl_b);
        if (a == depth)
            return init_b;
        if (a == depth + 32'd1)
            return ctrl_b;
        return array_word(a, dw, seed);
    endfunction

endpackage

// File: rtl/rrom_array.sv
module rrom_array
    import rrom_pkg::*;
#(
    parameter int unsigned LOC_W     = 14,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DEPTH     = 8192,
    parameter logic [31:0] SEED      = 32'hA5,
    parameter logic [31:0] INIT_BYTE = 32'h3C,
    parameter logic [31:0] CTRL_BYTE = 32'h00
) (
    input  logic [LOC_W-1:0]  loc,
    output logic [DATA_W-1:0] word
);

    logic [31:0] raw;

    always_comb begin
        raw  = image_word(32'(loc), DEPTH, DATA_W, SEED, INIT_BYTE, CTRL_BYTE);
        word = raw[DATA_W-1:0];
    end

endmodule

// File: rtl/rrom_pipe.sv
module rrom_pipe
    import rrom_pkg::*;
#(
    parameter int unsigned       DATA_W   = 8,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  logic              init_n,
    input  load_ctrl_t        ctl,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Initialize wins over the clock and holds the register while low
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n)
            q <= INIT_VAL;
        else if (ctl.clear)
            q <= '0;
        else if (ctl.load)
            q <= d;
    end

endmodule

// File: rtl/rrom_oe.sv
module rrom_oe
    import rrom_pkg::*;
#(
    parameter oe_kind_e KIND = OE_ASYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    output logic oe
);

    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst)
            oe_q <= 1'b0;
        else
            oe_q <= ~en_n;
    end

    always_comb begin
        case (KIND)
            OE_SYNC:     oe = oe_q;
            OE_FIXED_ON: oe = 1'b1;
            default:     oe = ~en_n;
        endcase
    end

endmodule

// File: rtl/reg_init_rom.sv
module reg_init_rom
    import rrom_pkg::*;
#(
    parameter int unsigned       ADDR_W    = ROM_ADDR_W,
    parameter int unsigned       DATA_W    = ROM_DATA_W,
    parameter logic [DATA_W-1:0] SEED      = 8'hA5,
    parameter logic [DATA_W-1:0] INIT_BYTE = 8'h3C,
    parameter logic [7:0]        CTRL_BYTE = CODE_ASYNC_EN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_sel,
    input  logic              init_n,
    input  logic              en_n,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    localparam int unsigned LOC_W    = ADDR_W + 1;
    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam logic [31:0] INIT_LOC = 32'(DEPTH);
    localparam logic [31:0] CTRL_LOC = 32'(DEPTH) + 32'd1;
    localparam logic [DATA_W-1:0] INIT_VAL =
        DATA_W'(image_word(INIT_LOC, 32'(DEPTH), DATA_W, 32'(SEED),
                           32'(INIT_BYTE), 32'(CTRL_BYTE)));
    localparam logic [7:0] CTRL_VAL =
        8'(image_word(CTRL_LOC, 32'(DEPTH), DATA_W, 32'(SEED),
                      32'(INIT_BYTE), 32'(CTRL_BYTE)));
    localparam oe_kind_e OE_KIND = decode_ctrl(CTRL_VAL);

    logic [DATA_W-1:0] rd_word;
    load_ctrl_t        ctl;

    rrom_array #(
        .LOC_W    (LOC_W),
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .SEED     (32'(SEED)),
        .INIT_BYTE(32'(INIT_BYTE)),
        .CTRL_BYTE(32'(CTRL_BYTE))
    ) u_array (
        .loc (LOC_W'(addr)),
        .word(rd_word)
    );

    always_comb begin
        ctl.clear = rst;
        ctl.load  = ~mode_sel;
    end

    rrom_pipe #(
        .DATA_W  (DATA_W),
        .INIT_VAL(INIT_VAL)
    ) u_pipe (
        .clk   (clk),
        .init_n(init_n),
        .ctl   (ctl),
        .d     (rd_word),
        .q     (dout)
    );

    rrom_oe #(
        .KIND(OE_KIND)
    ) u_oe (
        .clk (clk),
        .rst (rst),
        .en_n(en_n),
        .oe  (oe)
    );

endmodule

// File: rtl/rrom_chk.sv
module rrom_chk
    import rrom_pkg::*;
#(
    parameter int unsigned       DATA_W   = 8,
    parameter logic [DATA_W-1:0] INIT_VAL = '0,
    parameter oe_kind_e          KIND     = OE_ASYNC
) (
    input logic              clk,
    input logic              rst,
    input logic              init_n,
    input logic              mode_sel,
    input logic              en_n,
    input logic [DATA_W-1:0] dout,
    input logic              oe,
    input logic [DATA_W-1:0] rd_word
);

    assert_word_load_R1: assert property (@(posedge clk) disable iff (rst)
        (init_n && !mode_sel) |=> (!init_n || dout == $past(rd_word)));

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (init_n && mode_sel) |=> (!init_n || $stable(dout)));

    assert_init_value_R4: assert property (@(posedge clk) disable iff (rst)
        !init_n |-> dout == INIT_VAL);

    assert_clock_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
        !init_n |=> (init_n || $stable(dout)));

    generate
        if (KIND == OE_SYNC) begin : g_sync
            assert_sync_on_R7: assert property (@(posedge clk) disable iff (rst)
                !en_n |=> oe);
            assert_sync_off_R7: assert property (@(posedge clk) disable iff (rst)
                en_n |=> !oe);
        end else if (KIND == OE_FIXED_ON) begin : g_fixed
            assert_fixed_on_R8: assert property (@(posedge clk) disable iff (rst)
                oe);
        end else begin : g_async
            assert_async_follow_R6: assert property (@(posedge clk) disable iff (rst)
                oe == !en_n);
        end
    endgenerate

endmodule

bind reg_init_rom rrom_chk #(
    .DATA_W  (DATA_W),
    .INIT_VAL(INIT_VAL),
    .KIND    (OE_KIND)
) u_rrom_chk (
    .clk     (clk),
    .rst     (rst),
    .init_n  (init_n),
    .mode_sel(mode_sel),
    .en_n    (en_n),
    .dout    (dout),
    .oe      (oe),
    .rd_word (rd_word)
);

// File: tb/test_reg_init_rom.sv
module test_reg_init_rom;

    localparam logic [7:0] T_SEED = 8'hA5;
    localparam logic [7:0] T_INIT = 8'h3C;

    typedef struct {
        logic [7:0] d;
        logic       oe_a;
        logic       oe_s;
        logic       oe_f;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic        mode_sel = 1'b0;
    logic        init_n = 1'b1;
    logic        en_n = 1'b1;
    logic [7:0]  dout_a, dout_s, dout_f;
    logic        oe_a, oe_s, oe_f;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    logic [7:0] mdl_d = 8'h00;
    logic       mdl_s = 1'b0;

    always #4 clk = ~clk;

    reg_init_rom #(.CTRL_BYTE(8'h00)) i_reg_init_rom (
        .clk(clk), .rst(rst), .addr(addr), .mode_sel(mode_sel),
        .init_n(init_n), .en_n(en_n), .dout(dout_a), .oe(oe_a));
    reg_init_rom #(.CTRL_BYTE(8'h01)) i_reg_init_rom_sync (
        .clk(clk), .rst(rst), .addr(addr), .mode_sel(mode_sel),
        .init_n(init_n), .en_n(en_n), .dout(dout_s), .oe(oe_s));
    reg_init_rom #(.CTRL_BYTE(8'h02)) i_reg_init_rom_fix (
        .clk(clk), .rst(rst), .addr(addr), .mode_sel(mode_sel),
        .init_n(init_n), .en_n(en_n), .dout(dout_f), .oe(oe_f));

    function automatic logic [7:0] word_of(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b000} ^ T_SEED;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: set inputs after a falling edge, push what the next rising edge must produce
    task automatic step(input logic [12:0] a, input logic m, input logic e,
                        input logic ini, input logic r, input string tag);
        exp_t it;
        @(negedge clk);
        addr = a; mode_sel = m; en_n = e; init_n = ini; rst = r;
        if (!ini) mdl_d = T_INIT;
        else if (r) mdl_d = 8'h00;
        else if (!m) mdl_d = word_of(a);
        mdl_s = r ? 1'b0 : ~e;
        it.d = mdl_d; it.oe_a = ~e; it.oe_s = mdl_s; it.oe_f = 1'b1; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare shortly after each rising edge
    initial begin
        forever begin
            exp_t it;
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                check({it.tag, " dout"}, 32'(dout_a), 32'(it.d));
                check({it.tag, " dout sync"}, 32'(dout_s), 32'(it.d));
                check({it.tag, " dout fixed"}, 32'(dout_f), 32'(it.d));
                check("R6 oe async", 32'(oe_a), 32'(it.oe_a));
                check("R7 oe sync", 32'(oe_s), 32'(it.oe_s));
                check("R8 oe fixed", 32'(oe_f), 32'(it.oe_f));
            end
        end
    end

    initial begin
        #(8 * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        check("R2 reset dout", 32'(dout_a), 32'h00);
        check("R2 reset sync oe", 32'(oe_s), 32'h0);
        check("R8 fixed oe in reset", 32'(oe_f), 32'h1);

        // R1 / R6 / R7: loads under several address and enable patterns
        step(13'h0000, 1'b0, 1'b1, 1'b1, 1'b0, "R1 addr 0000");
        step(13'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0, "R1 addr 1FFF");
        step(13'h1234, 1'b0, 1'b0, 1'b1, 1'b0, "R1 addr 1234");
        step(13'h0AAA, 1'b0, 1'b1, 1'b1, 1'b0, "R1 addr 0AAA");
        step(13'h1555, 1'b0, 1'b0, 1'b1, 1'b0, "R1 addr 1555");
        step(13'h0100, 1'b0, 1'b0, 1'b1, 1'b0, "R1 addr 0100");
        // R3: frozen register while mode_sel is high
        step(13'h0F0F, 1'b1, 1'b1, 1'b1, 1'b0, "R3 hold");
        step(13'h1E1E, 1'b1, 1'b0, 1'b1, 1'b0, "R3 hold");
        step(13'h0777, 1'b0, 1'b0, 1'b1, 1'b0, "R1 after hold");
        repeat (2) @(posedge clk);

        // R6 / R7 / R8: mid-cycle enable change before any edge
        @(negedge clk);
        #1 en_n = 1'b1;
        #1;
        check("R6 async oe off at once", 32'(oe_a), 32'h0);
        check("R7 sync oe waits for edge", 32'(oe_s), 32'h1);
        check("R8 fixed oe ignores en_n", 32'(oe_f), 32'h1);
        #1 en_n = 1'b0;
        #1;
        check("R6 async oe on at once", 32'(oe_a), 32'h1);

        // R4: initialize falls between edges
        step(13'h0321, 1'b0, 1'b0, 1'b1, 1'b0, "R1 before init");
        @(posedge clk);
        @(negedge clk);
        #1 init_n = 1'b0;
        #1;
        check("R4 init immediate", 32'(dout_a), 32'(T_INIT));
        check("R4 init immediate sync", 32'(dout_s), 32'(T_INIT));
        mdl_d = T_INIT;
        // R5: edges ignored while init is low, then resume
        step(13'h1111, 1'b0, 1'b0, 1'b0, 1'b0, "R5 inhibit");
        step(13'h0ABC, 1'b0, 1'b1, 1'b0, 1'b0, "R5 inhibit");
        step(13'h1FF0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 resume");
        step(13'h0042, 1'b0, 1'b0, 1'b1, 1'b0, "R5 resume");
        // R2: reset mid run
        step(13'h0042, 1'b0, 1'b0, 1'b1, 1'b1, "R2 reset again");
        step(13'h1357, 1'b0, 1'b0, 1'b1, 1'b0, "R1 after reset");
        repeat (2) @(posedge clk);
        #3;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule